// File: doc/BRIEF.md
# Four-Category Contention Backoff Engine

This block arbitrates channel access between four traffic categories that share one transmitter. Category 0 carries best-effort traffic, 1 background, 2 video and 3 voice. Each category has its own arbitration slot count, its own pair of contention-window exponents (a floor and a ceiling) and its own transmit-opportunity limit. The configuration enters as packed input vectors, and each category's field sits at bits `[4*i +: 4]`. Once the medium goes idle, the engine waits one short interframe space (SIFS). Each category then waits its own number of slots, and after that counts down a random backoff one idle slot at a time. A category whose count reaches zero while it has a frame pending takes the medium. The engine pulses a grant, reports which category won, and holds an opportunity window open for that category.

The short interframe space and the slot length are 8-bit values counted in microseconds. A prescaler parameter gives the number of clock cycles in one microsecond. The opportunity limit is counted in 32 µs units. A limit of zero allows one frame per access. A failed exchange raises the category's window exponent. A successful exchange returns it to the floor. When two categories are ready in the same cycle, the higher index transmits and the others redraw with a wider window. A 2-bit access mode per category can replace the backoff with a fixed wait of SIFS plus one slot. It can also replace it with a bare SIFS, allowed only when that category's previous exchange succeeded.

Top module: `edca_backoff_engine`

## Requirements
- R1: After reset, `grant` and `txop_active` are 0 and `grant_ac` is 0. Every category starts with a backoff of zero and its window exponent at the floor.
- R2: Let the medium go idle just before clock edge 1, and let P be clocks per microsecond. A mode-2 category with pending set and backoff zero shows `grant` after edge (SIFS + AIFSN·SLOT)·P + 1. At that point `grant_ac` holds its index.
- R3: A nonzero backoff B decreases by one at the end of each idle slot that starts after the category's arbitration slots. This happens only while the category is pending and no opportunity is open. The grant therefore comes after edge (SIFS + (AIFSN + B)·SLOT)·P + 1.
- R4: A failed exchange raises the exponent by one, up to the ceiling. A success returns it to the floor. A new backoff is drawn at the end of every opportunity. It equals a 16-bit LFSR value (taps 16,14,13,11, shifted left, new bit in bit 0, seed 0xACE1), rotated left by 4·index and masked to 2^e − 1. The LFSR advances once per cycle in which any draw occurs.
- R5: When the medium turns busy, the backoff count freezes and the SIFS and slot timing restarts. After the medium is released, counting resumes from the remaining value once the arbitration slots have elapsed again.
- R6: When several categories are ready in the same cycle, the highest index is granted. `grant` is a one-cycle pulse, and `txop_active` rises only with a grant.
- R7: A category that is ready but loses arbitration raises its exponent as on a failure and redraws its backoff in that same cycle.
- R8: With a limit of zero, `txop_active` stays high until a `tx_ok` or `tx_fail` pulse and falls on the edge that samples it. No second grant happens while it is high.
- R9: With a limit L > 0, `txop_active` stays high for exactly L·32·P cycles from the grant edge. A `tx_ok` inside the window does not shorten it.
- R10: A `tx_fail` pulse during an opportunity closes it on the next edge.
- R11: Mode 1 (fixed wait) grants after edge (SIFS + SLOT)·P + 1, whatever the backoff. Mode 3 grants after edge SIFS·P + 1 if the category's previous exchange succeeded. Otherwise it behaves like mode 2, and so does mode 0.
- R12: With no category pending, no grant is issued, however long the medium stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| medium_busy | input | 1 | Channel busy indication |
| tx_ok | input | 1 | One-cycle pulse: exchange succeeded |
| tx_fail | input | 1 | One-cycle pulse: exchange failed |
| ac_pending | input | 4 | Frame waiting, one bit per category |
| ac_mode | input | 8 | Access mode, 2 bits per category (0 opportunity rule, 1 fixed wait, 2 backoff, 3 SIFS after success) |
| aifsn_cfg | input | 16 | Arbitration slot count per category |
| cwmin_cfg | input | 16 | Window floor exponent per category |
| cwmax_cfg | input | 16 | Window ceiling exponent per category |
| txop_cfg | input | 4*TXOP_W | Opportunity limit per category, 32 µs units |
| sifs_us | input | 8 | Short interframe space in µs |
| slot_us | input | 8 | Slot length in µs |
| grant | output | 1 | One-cycle access grant |
| grant_ac | output | 2 | Index of the granted category |
| txop_active | output | 1 | Opportunity window open |

## Verification
The bench uses two clocks per microsecond, so a 32 µs opportunity unit lasts 64 cycles. With SIFS = 3 µs and a 2 µs slot, every wait falls a few dozen cycles after the release of the medium. The LFSR seed is left at its default, which lets the bench model every draw and predict the exact grant edge of each access. Window ceilings of 3 to 5 keep random backoffs short. The ceiling saturation, the loser redraw after a simultaneous-ready collision, the busy freeze in the middle of a countdown and both bypass modes are each reached within a few accesses.

// File: rtl/edca_pkg.sv
package edca_pkg;
  localparam int NUM_AC = 4;
  localparam int RND_W  = 16;

  typedef enum logic [1:0] {
    MODE_TXOP_RULE  = 2'd0,
    MODE_PIFS       = 2'd1,
    MODE_BACKOFF    = 2'd2,
    MODE_SIFS_CHAIN = 2'd3
  } access_mode_e;

  // Fibonacci LFSR, taps 16,14,13,11.
  function automatic logic [RND_W-1:0] lfsr_step(input logic [RND_W-1:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Window exponent: floor plus failure stage, clamped at the ceiling.
  function automatic logic [3:0] cw_exp(input logic [3:0] cmin, input logic [3:0] cmax,
                                        input logic [3:0] stage);
    logic [4:0] sum;
    sum = {1'b0, cmin} + {1'b0, stage};
    if (sum > {1'b0, cmax}) return cmax;
    return sum[3:0];
  endfunction

  function automatic logic [RND_W-1:0] cw_mask(input logic [3:0] e);
    return (RND_W'(1) << e) - RND_W'(1);
  endfunction

  // Rotate left by sh (< 16) and mask to the window.
  function automatic logic [RND_W-1:0] draw_backoff(input logic [RND_W-1:0] rnd,
                                                    input int unsigned sh,
                                                    input logic [3:0] e);
    logic [2*RND_W-1:0] dbl;
    dbl = {rnd, rnd} << sh;
    return dbl[2*RND_W-1:RND_W] & cw_mask(e);
  endfunction
endpackage

// File: rtl/edca_idle_timer.sv
module edca_idle_timer #(
  parameter int unsigned CLKS_PER_US = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       medium_busy,
  input  logic [7:0] sifs_us,
  input  logic [7:0] slot_us,
  output logic       in_slots,
  output logic [4:0] slots,
  output logic       slot_tick
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PW-1:0] US_LAST = PW'(CLKS_PER_US - 1);

  logic [PW-1:0] us_cnt;
  logic [7:0]    ph_us;
  logic          us_tick, sifs_end;
  logic [8:0]    ph_next;

  assign us_tick   = !medium_busy && (us_cnt == US_LAST);
  assign ph_next   = {1'b0, ph_us} + 9'd1;
  assign sifs_end  = us_tick && !in_slots && (ph_next >= {1'b0, sifs_us});
  assign slot_tick = us_tick && in_slots && (ph_next >= {1'b0, slot_us});

  always_ff @(posedge clk) begin
    if (!rst_n || medium_busy) begin
      us_cnt   <= '0;
      ph_us    <= '0;
      in_slots <= 1'b0;
      slots    <= '0;
    end else begin
      us_cnt <= us_tick ? '0 : us_cnt + PW'(1);
      if (sifs_end) begin
        in_slots <= 1'b1;
        ph_us    <= '0;
      end else if (slot_tick) begin
        ph_us <= '0;
        if (slots != 5'h1F) slots <= slots + 5'd1;
      end else if (us_tick) begin
        ph_us <= ph_us + 8'd1;
      end
    end
  end

  // R5: a busy medium restarts interframe timing
  assert_busy_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    medium_busy |=> (!in_slots && slots == 5'd0));
endmodule

// File: rtl/edca_ac_unit.sv
module edca_ac_unit
  import edca_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       aifsn,
  input  logic [3:0]       cwmin,
  input  logic [3:0]       cwmax,
  input  logic [1:0]       mode,
  input  logic             pending,
  input  logic             in_slots,
  input  logic [4:0]       slots,
  input  logic             slot_tick,
  input  logic             hold,
  input  logic             lose,
  input  logic             end_ok,
  input  logic             end_fail,
  input  logic [RND_W-1:0] rnd,
  output logic             ready
);
  logic [3:0]       stage, stage_nxt;
  logic [RND_W-1:0] bo_q;
  logic             last_ok;
  logic             draw_ev, aifs_done, count_en;

  assign draw_ev   = lose || end_ok || end_fail;
  assign stage_nxt = end_ok ? 4'd0 : ((stage == 4'hF) ? stage : stage + 4'd1);
  assign aifs_done = in_slots && ({1'b0, aifsn} <= slots);
  assign count_en  = slot_tick && pending && !hold && aifs_done && (bo_q != '0);

  always_comb begin
    ready = 1'b0;
    if (pending && !hold) begin
      case (access_mode_e'(mode))
        MODE_PIFS:       ready = (slots != 5'd0);
        MODE_SIFS_CHAIN: ready = last_ok ? in_slots : (aifs_done && bo_q == '0);
        default:         ready = aifs_done && (bo_q == '0);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage   <= '0;
      bo_q    <= '0;
      last_ok <= 1'b0;
    end else if (draw_ev) begin
      stage   <= stage_nxt;
      bo_q    <= draw_backoff(rnd, 4 * IDX, cw_exp(cwmin, cwmax, stage_nxt));
      last_ok <= end_ok;
    end else if (count_en) begin
      bo_q <= bo_q - RND_W'(1);
    end
  end

  // R3: without a draw the backoff never grows
  assert_backoff_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !draw_ev |=> (bo_q <= $past(bo_q)));
  // R5: a busy medium freezes the count
  assert_busy_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !draw_ev) |=> $stable(bo_q));
endmodule

// File: rtl/edca_txop_timer.sv
module edca_txop_timer #(
  parameter int unsigned TXOP_W      = 8,
  parameter int unsigned CLKS_PER_US = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TXOP_W-1:0] limit,
  input  logic              tx_ok,
  input  logic              tx_fail,
  output logic              active,
  output logic              end_ok,
  output logic              end_fail
);
  localparam int CW = TXOP_W + 5 + $clog2(CLKS_PER_US + 1);

  logic [TXOP_W-1:0] lim_q;
  logic [CW-1:0]     cnt, win;
  logic              expire;

  assign win      = (CW'(lim_q) << 5) * CW'(CLKS_PER_US);
  assign expire   = active && (lim_q != '0) && (cnt == win - CW'(1));
  assign end_fail = active && tx_fail;
  assign end_ok   = active && !tx_fail && ((tx_ok && lim_q == '0) || expire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      lim_q  <= '0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      lim_q  <= limit;
      cnt    <= '0;
    end else if (end_ok || end_fail) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt + CW'(1);
    end
  end

  // R8: a zero limit holds the window until a result arrives
  assert_zero_limit_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && lim_q == '0 && !tx_ok && !tx_fail) |=> active);
  // R10: a failure closes the window
  assert_fail_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tx_fail) |=> !active);
endmodule

// File: rtl/edca_backoff_engine.sv
module edca_backoff_engine
  import edca_pkg::*;
#(
  parameter int unsigned TXOP_W      = 8,
  parameter int unsigned CLKS_PER_US = 40,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     medium_busy,
  input  logic                     tx_ok,
  input  logic                     tx_fail,
  input  logic [NUM_AC-1:0]        ac_pending,
  input  logic [2*NUM_AC-1:0]      ac_mode,
  input  logic [4*NUM_AC-1:0]      aifsn_cfg,
  input  logic [4*NUM_AC-1:0]      cwmin_cfg,
  input  logic [4*NUM_AC-1:0]      cwmax_cfg,
  input  logic [TXOP_W*NUM_AC-1:0] txop_cfg,
  input  logic [7:0]               sifs_us,
  input  logic [7:0]               slot_us,
  output logic                     grant,
  output logic [1:0]               grant_ac,
  output logic                     txop_active
);
  logic              in_slots, slot_tick, hold, any_ready, draw_any;
  logic              end_ok, end_fail;
  logic [4:0]        slots;
  logic [NUM_AC-1:0] ready, lose;
  logic [1:0]        winner;
  logic [RND_W-1:0]  lfsr;

  assign hold = medium_busy || txop_active;

  edca_idle_timer #(.CLKS_PER_US(CLKS_PER_US)) u_idle (
    .clk(clk), .rst_n(rst_n), .medium_busy(medium_busy),
    .sifs_us(sifs_us), .slot_us(slot_us),
    .in_slots(in_slots), .slots(slots), .slot_tick(slot_tick));

  for (genvar i = 0; i < NUM_AC; i++) begin : g_ac
    assign lose[i] = ready[i] && (winner != 2'(i));
    edca_ac_unit #(.IDX(i)) u_ac (
      .clk(clk), .rst_n(rst_n),
      .aifsn(aifsn_cfg[4*i +: 4]), .cwmin(cwmin_cfg[4*i +: 4]),
      .cwmax(cwmax_cfg[4*i +: 4]), .mode(ac_mode[2*i +: 2]),
      .pending(ac_pending[i]), .in_slots(in_slots), .slots(slots),
      .slot_tick(slot_tick), .hold(hold), .lose(lose[i]),
      .end_ok(end_ok && grant_ac == 2'(i)),
      .end_fail(end_fail && grant_ac == 2'(i)),
      .rnd(lfsr), .ready(ready[i]));
  end

  // Highest ready index wins.
  always_comb begin
    winner = 2'd0;
    for (int i = 0; i < NUM_AC; i++)
      if (ready[i]) winner = 2'(i);
  end

  assign any_ready = |ready;
  assign draw_any  = end_ok || end_fail || (|lose);

  edca_txop_timer #(.TXOP_W(TXOP_W), .CLKS_PER_US(CLKS_PER_US)) u_txop (
    .clk(clk), .rst_n(rst_n), .start(any_ready),
    .limit(txop_cfg[winner*TXOP_W +: TXOP_W]),
    .tx_ok(tx_ok), .tx_fail(tx_fail),
    .active(txop_active), .end_ok(end_ok), .end_fail(end_fail));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant    <= 1'b0;
      grant_ac <= '0;
      lfsr     <= LFSR_SEED;
    end else begin
      grant <= any_ready;
      if (any_ready) grant_ac <= winner;
      if (draw_any)  lfsr <= lfsr_step(lfsr);
    end
  end

  // R6: grant is a single pulse
  assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  // R6: the window only opens through a grant
  assert_open_by_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txop_active) |-> grant);
  // R8: no grant while a window is open
  assert_no_grant_in_txop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txop_active |=> (!grant || $fell(txop_active) || !$past(txop_active)));
endmodule

// File: tb/edca_backoff_engine_test.sv
module edca_backoff_engine_test;
  localparam int CPU = 2;
  localparam int S   = 3;
  localparam int T   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic medium_busy = 1'b1, tx_ok = 1'b0, tx_fail = 1'b0;
  logic [3:0]  ac_pending = '0;
  logic [7:0]  ac_mode;
  logic [15:0] aifsn_cfg, cwmin_cfg, cwmax_cfg;
  logic [31:0] txop_cfg;
  logic        grant, txop_active;
  logic [1:0]  grant_ac;

  int aifsn_v[4], cwmin_v[4], cwmax_v[4], txop_v[4], mode_v[4];
  int stage_m[4], bo_m[4];
  bit lastok_m[4];
  logic [15:0] lfsr_m = 16'hACE1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      aifsn_cfg[4*i +: 4] = 4'(aifsn_v[i]);
      cwmin_cfg[4*i +: 4] = 4'(cwmin_v[i]);
      cwmax_cfg[4*i +: 4] = 4'(cwmax_v[i]);
      ac_mode[2*i +: 2]   = 2'(mode_v[i]);
      txop_cfg[8*i +: 8]  = 8'(txop_v[i]);
    end
  end

  edca_backoff_engine #(.TXOP_W(8), .CLKS_PER_US(CPU), .LFSR_SEED(16'hACE1)) uut (
    .clk(clk), .rst_n(rst_n), .medium_busy(medium_busy), .tx_ok(tx_ok), .tx_fail(tx_fail),
    .ac_pending(ac_pending), .ac_mode(ac_mode), .aifsn_cfg(aifsn_cfg), .cwmin_cfg(cwmin_cfg),
    .cwmax_cfg(cwmax_cfg), .txop_cfg(txop_cfg), .sifs_us(8'(S)), .slot_us(8'(T)),
    .grant(grant), .grant_ac(grant_ac), .txop_active(txop_active));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---- reference model ----
  function automatic int exp_of(input int i);
    int s = cwmin_v[i] + stage_m[i];
    return (s > cwmax_v[i]) ? cwmax_v[i] : s;
  endfunction

  function automatic void model_draw(input int i);
    logic [31:0] two;
    int e;
    e = exp_of(i);
    two = {lfsr_m, lfsr_m} >> (16 - 4 * i);
    bo_m[i] = int'(two[15:0]) & ((1 << e) - 1);
  endfunction

  function automatic void model_step();
    lfsr_m = {lfsr_m[14:0], ^(lfsr_m & 16'hB400)};
  endfunction

  function automatic int exp_delay(input int ac);
    if (mode_v[ac] == 3 && lastok_m[ac]) return S * CPU + 1;
    if (mode_v[ac] == 1) return (S + T) * CPU + 1;
    return (S + (aifsn_v[ac] + bo_m[ac]) * T) * CPU + 1;
  endfunction

  // Release the medium and count edges until grant.
  task automatic run_until_grant(input logic [3:0] pend, output int n);
    @(negedge clk);
    ac_pending  = pend;
    medium_busy = 1'b0;
    n = -1;
    for (int k = 1; k <= 3000; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (grant) begin n = k; break; end
    end
    medium_busy = 1'b1;
  endtask

  task automatic access(input int ac, input string req);
    int n;
    int e;
    e = exp_delay(ac);
    run_until_grant(4'(1 << ac), n);
    chk(req, "grant delay", n, e);
    chk(req, "grant_ac", int'(grant_ac), ac);
  endtask

  task automatic finish_ok(input int ac, input string req);
    tx_ok = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_ok = 1'b0;
    ac_pending = '0;
    chk(req, "txop closed by tx_ok", int'(txop_active), 0);
    stage_m[ac] = 0; lastok_m[ac] = 1; model_draw(ac); model_step();
  endtask

  task automatic finish_fail(input int ac, input string req);
    tx_fail = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_fail = 1'b0;
    ac_pending = '0;
    chk(req, "txop closed by tx_fail", int'(txop_active), 0);
    if (stage_m[ac] < 15) stage_m[ac]++;
    lastok_m[ac] = 0; model_draw(ac); model_step();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int pre;
    void'($urandom(32'd7));
    aifsn_v = '{3, 7, 2, 2};
    cwmin_v = '{4, 4, 3, 2};
    cwmax_v = '{5, 5, 4, 3};
    txop_v  = '{0, 0, 0, 1};
    mode_v  = '{2, 2, 2, 2};
    for (int i = 0; i < 4; i++) begin stage_m[i] = 0; bo_m[i] = 0; lastok_m[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "grant after reset", int'(grant), 0);
    chk("R1", "txop_active after reset", int'(txop_active), 0);
    chk("R1", "grant_ac after reset", int'(grant_ac), 0);

    // R6/R7: background and voice ready together with equal spacing
    aifsn_v[1] = 2;
    run_until_grant(4'b1010, n);
    chk("R6", "collision delay", n, (S + 2 * T) * CPU + 1);
    chk("R6", "higher index wins", int'(grant_ac), 3);
    if (stage_m[1] < 15) stage_m[1]++;
    lastok_m[1] = 0; model_draw(1); model_step();
    ac_pending = 4'b1000;
    // R9: one 32 us unit = 64 cycles; tx_ok inside is ignored
    for (int k = 1; k <= 32 * CPU; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 10) tx_ok = 1'b1;
      if (k == 11) tx_ok = 1'b0;
      if (k == 12) chk("R9", "tx_ok inside window ignored", int'(txop_active), 1);
      if (k == 32 * CPU - 1) chk("R9", "window still open", int'(txop_active), 1);
      if (k == 32 * CPU) chk("R9", "window closed", int'(txop_active), 0);
    end
    stage_m[3] = 0; lastok_m[3] = 1; model_draw(3); model_step();
    ac_pending = '0;
    aifsn_v[1] = 7;

    // R2: video first access with zero backoff
    access(2, "R2");
    // R8: zero limit holds until a result, no regrant
    ac_pending = 4'b0101;
    medium_busy = 1'b0;
    pre = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (grant) pre++;
    end
    medium_busy = 1'b1;
    chk("R8", "no grant while window open", pre, 0);
    chk("R8", "window held at zero limit", int'(txop_active), 1);
    ac_pending = 4'b0100;
    finish_ok(2, "R8");

    // R7: loser of the collision uses its widened redraw
    access(1, "R7");
    finish_fail(1, "R10");
    // R4: repeated failures saturate at the ceiling
    for (int r = 0; r < 4; r++) begin
      access(1, "R4");
      finish_fail(1, "R4");
    end
    access(1, "R4");
    finish_ok(1, "R4");
    access(1, "R4");
    finish_ok(1, "R3");

    // R5: freeze mid-countdown
    for (int r = 0; r < 8 && bo_m[0] < 2; r++) begin
      access(0, "R3");
      finish_fail(0, "R4");
    end
    if (bo_m[0] >= 2) begin
      @(negedge clk);
      ac_pending = 4'b0001;
      medium_busy = 1'b0;
      pre = 0;
      for (int k = 1; k <= (S + (aifsn_v[0] + 1) * T) * CPU; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (grant) pre++;
      end
      medium_busy = 1'b1;
      chk("R5", "no grant before busy", pre, 0);
      bo_m[0] = bo_m[0] - 1;
      repeat (5) @(negedge clk);
      access(0, "R5");
      finish_ok(0, "R5");
    end

    // R11: access modes
    mode_v[0] = 1;
    access(0, "R11");
    finish_ok(0, "R11");
    mode_v[0] = 3;
    access(0, "R11");
    finish_fail(0, "R11");
    access(0, "R11");
    finish_ok(0, "R11");
    mode_v[0] = 2;

    // R12: nothing pending, no grant
    @(negedge clk);
    ac_pending = '0;
    medium_busy = 1'b0;
    pre = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (grant) pre++;
    end
    medium_busy = 1'b1;
    chk("R12", "no grant without pending", pre, 0);
    chk("R12", "no window without pending", int'(txop_active), 0);

    // Random accesses
    txop_v = '{0, 0, 0, 0};
    for (int it = 0; it < 30; it++) begin
      int ac;
      ac = int'($urandom % 4);
      aifsn_v[ac] = int'($urandom % 6);
      repeat (2) @(negedge clk);
      access(ac, "R3");
      if ($urandom % 2) finish_ok(ac, "R4");
      else finish_fail(ac, "R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule